// File: doc/BRIEF.md
# Sample-Set Buffer RAM Controller

This block keeps a small RAM of processed sample sets and hands them out only when asked. Each slot holds one set of five 16-bit fields: in-phase (I), quadrature (Q), magnitude, phase and frequency. A set is written as a whole from five parallel field inputs when the sample-valid strobe is high.

Reads come through two ports. A 16-bit port serves a baseband engine and returns a whole field. An 8-bit port serves a configuration microprocessor and returns one byte of a field. Both ports pick a field of the oldest stored set with a 3-bit field code. Reading the frequency field, which is the last field of a set, retires that set.

Two capture modes are available. In FIFO mode every valid set is stored while there is room. In snapshot mode an arm pulse empties the buffer and records exactly one full buffer of consecutive sets. Capture then stops and a done flag stays high until the next arm. The frequency input has its own strobe. When no new frequency value arrives with a set, the most recent frequency value is stored in its place.

Top module: `sset_buf_ctrl`

## Requirements
- R1: After reset, empty is 1, full is 0, snap_done is 0, and both acknowledge outputs are 0.
- R2: In FIFO mode (mode_snap=0), a set is written on each cycle with in_valid=1 while full is 0. Full rises when 8 sets are held. A set offered while full is dropped, so 8 retiring reads in a row empty the buffer and return the sets in write order.
- R3: An engine read (eng_rd=1) returns, one clock later with eng_ack=1, the field of the oldest set selected by eng_code: 000=I, 001=Q, 010=magnitude, 011=phase, 100=frequency.
- R4: A host read (host_rd=1) returns, one clock later with host_ack=1, bits 15:8 of the selected field when host_hi=1 and bits 7:0 when host_hi=0. It uses the same field codes as R3.
- R5: A read with code 100 retires the oldest set. Reads of other codes leave it in place. A read while empty returns 0 and changes nothing.
- R6: Field codes 101, 110 and 111 return 0 on either port and never retire a set.
- R7: When both ports request in the same cycle, the engine read is served in that cycle. The host read is held and answered in the first later cycle with no engine request, one cycle after that.
- R8: The frequency value stored with a set is in_freq when in_freq_vld=1. Otherwise it is the last in_freq accepted with in_freq_vld=1, or 0 if none has been accepted since reset.
- R9: In snapshot mode (mode_snap=1), snap_arm empties the buffer and clears snap_done on the next clock, and it takes precedence over an in_valid in the same cycle. The next 8 valid sets are then captured, after which snap_done is 1 and stays 1 until the next arm.
- R10: In snapshot mode, in_valid has no effect once capture has stopped, even after the captured sets have been read out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample-set valid strobe |
| in_i | input | 16 | I field of the incoming set |
| in_q | input | 16 | Q field of the incoming set |
| in_mag | input | 16 | Magnitude field of the incoming set |
| in_phase | input | 16 | Phase field of the incoming set |
| in_freq | input | 16 | Frequency value |
| in_freq_vld | input | 1 | in_freq carries a new value this cycle |
| mode_snap | input | 1 | 0 = FIFO mode, 1 = snapshot mode |
| snap_arm | input | 1 | Snapshot arm pulse |
| eng_rd | input | 1 | Engine read request |
| eng_code | input | 3 | Engine field code |
| eng_data | output | 16 | Engine read data |
| eng_ack | output | 1 | Engine read data valid |
| host_rd | input | 1 | Host read request |
| host_code | input | 3 | Host field code |
| host_hi | input | 1 | Host byte select, 1 = upper byte |
| host_data | output | 8 | Host read data |
| host_ack | output | 1 | Host read data valid |
| empty | output | 1 | No set stored |
| full | output | 1 | All slots hold a set |
| snap_done | output | 1 | Snapshot capture finished |

## Verification
Two sets with distinct values in every field are read through both ports in a mixed order. This shows the field-code mapping, byte selection, unused codes, and that only a frequency read retires a set. The second set is written without a frequency strobe, which separates a held frequency from a freshly written one. A nine-set burst in FIFO mode, drained in order, tells a dropped overflow apart from an overwrite. Snapshot runs with ten offered sets and late writes show that capture stops at eight, and a same-cycle request on both ports shows the arbitration order and the one-cycle host delay.

// File: rtl/sset_pkg.sv
package sset_pkg;
   localparam int NUM_FIELDS   = 5;
   localparam int DEF_FIELD_W  = 16;
   localparam int DEF_DEPTH    = 8;
   localparam int DEF_CODE_W   = 3;

   typedef enum logic [2:0] {
      FC_I     = 3'd0,
      FC_Q     = 3'd1,
      FC_MAG   = 3'd2,
      FC_PHASE = 3'd3,
      FC_FREQ  = 3'd4
   } field_code_e;

   localparam int LAST_FIELD = int'(FC_FREQ);
endpackage

// File: rtl/sset_store.sv
module sset_store
   import sset_pkg::*;
#(
   parameter int FIELD_W = DEF_FIELD_W,
   parameter int DEPTH   = DEF_DEPTH,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int SET_W  = NUM_FIELDS * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [PTR_W-1:0]   wr_addr,
   input  logic [FIELD_W-1:0] in_i,
   input  logic [FIELD_W-1:0] in_q,
   input  logic [FIELD_W-1:0] in_mag,
   input  logic [FIELD_W-1:0] in_phase,
   input  logic [FIELD_W-1:0] in_freq,
   input  logic               in_freq_vld,
   input  logic [PTR_W-1:0]   rd_addr,
   output logic [SET_W-1:0]   head_set
);
   logic [SET_W-1:0]   slot_q [DEPTH];
   logic [FIELD_W-1:0] freq_hold_q;
   logic [FIELD_W-1:0] freq_eff;
   logic [SET_W-1:0]   wr_set;

   assign freq_eff = in_freq_vld ? in_freq : freq_hold_q;
   assign wr_set   = {freq_eff, in_phase, in_mag, in_q, in_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         freq_hold_q <= '0;
      end else if (in_freq_vld) begin
         freq_hold_q <= in_freq;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < DEPTH; s++) slot_q[s] <= '0;
      end else if (wr_en) begin
         slot_q[wr_addr] <= wr_set;
      end
   end

   assign head_set = slot_q[rd_addr];

   // R8: a set written without a frequency strobe carries the held value
   assert_freq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !in_freq_vld) |=>
         (slot_q[$past(wr_addr)][SET_W-1 -: FIELD_W] == $past(freq_hold_q)));
endmodule

// File: rtl/sset_ptr_ctrl.sv
module sset_ptr_ctrl
   import sset_pkg::*;
#(
   parameter int DEPTH  = DEF_DEPTH,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_snap,
   input  logic             snap_arm,
   input  logic             in_valid,
   input  logic             pop,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_addr,
   output logic [PTR_W-1:0] rd_addr,
   output logic             empty,
   output logic             full,
   output logic             snap_done
);
   logic [PTR_W-1:0] wptr_q, rptr_q;
   logic [CNT_W-1:0] cnt_q, cap_cnt_q;
   logic             capt_q, done_q;
   logic             arm;

   assign arm   = snap_arm & mode_snap;
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNT_W'(DEPTH));
   assign wr_en = !arm && in_valid && !full && (!mode_snap || capt_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q    <= '0;
         rptr_q    <= '0;
         cnt_q     <= '0;
         cap_cnt_q <= '0;
         capt_q    <= 1'b0;
         done_q    <= 1'b0;
      end else if (arm) begin
         wptr_q    <= '0;
         rptr_q    <= '0;
         cnt_q     <= '0;
         cap_cnt_q <= '0;
         capt_q    <= 1'b1;
         done_q    <= 1'b0;
      end else begin
         wptr_q <= wptr_q + PTR_W'(wr_en);
         rptr_q <= rptr_q + PTR_W'(pop);
         cnt_q  <= cnt_q + CNT_W'(wr_en) - CNT_W'(pop);
         if (!mode_snap) begin
            cap_cnt_q <= '0;
            capt_q    <= 1'b0;
            done_q    <= 1'b0;
         end else if (wr_en) begin
            cap_cnt_q <= cap_cnt_q + CNT_W'(1);
            if (cap_cnt_q == CNT_W'(DEPTH - 1)) begin
               capt_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign wr_addr   = wptr_q;
   assign rd_addr   = rptr_q;
   assign snap_done = done_q;

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop && !arm) |=> full);

   assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full));

   assert_arm_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> (empty && !snap_done));

   assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_done && mode_snap && !snap_arm) |=> snap_done);

   assert_stopped_ignores_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_snap && snap_done && !snap_arm) |-> !wr_en);
endmodule

// File: rtl/sset_rd_arb.sv
module sset_rd_arb
   import sset_pkg::*;
#(
   parameter int FIELD_W = DEF_FIELD_W,
   parameter int CODE_W  = DEF_CODE_W,
   localparam int BYTE_W = FIELD_W / 2,
   localparam int SET_W  = NUM_FIELDS * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SET_W-1:0]   head_set,
   input  logic               empty,
   input  logic               eng_rd,
   input  logic [CODE_W-1:0]  eng_code,
   output logic [FIELD_W-1:0] eng_data,
   output logic               eng_ack,
   input  logic               host_rd,
   input  logic [CODE_W-1:0]  host_code,
   input  logic               host_hi,
   output logic [BYTE_W-1:0]  host_data,
   output logic               host_ack,
   output logic               pop
);
   logic [FIELD_W-1:0] fld [NUM_FIELDS];
   logic               pend_q, phi_q;
   logic [CODE_W-1:0]  pcode_q;
   logic               host_req, host_srv, h_hi;
   logic [CODE_W-1:0]  h_code, srv_code;
   logic [FIELD_W-1:0] eng_fld, host_fld;

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
      assign fld[g] = head_set[g*FIELD_W +: FIELD_W];
   end

   function automatic logic [FIELD_W-1:0] pick(input logic [CODE_W-1:0] code,
                                               input logic is_empty);
      logic [FIELD_W-1:0] r;
      r = '0;
      if (!is_empty) begin
         for (int k = 0; k < NUM_FIELDS; k++)
            if (code == CODE_W'(k)) r = fld[k];
      end
      return r;
   endfunction

   assign host_req = pend_q | host_rd;
   assign h_code   = pend_q ? pcode_q : host_code;
   assign h_hi     = pend_q ? phi_q : host_hi;
   assign host_srv = host_req & ~eng_rd;
   assign srv_code = eng_rd ? eng_code : h_code;
   assign pop      = (eng_rd | host_srv) && !empty &&
                     (srv_code == CODE_W'(LAST_FIELD));
   assign eng_fld  = pick(eng_code, empty);
   assign host_fld = pick(h_code, empty);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         phi_q     <= 1'b0;
         pcode_q   <= '0;
         eng_ack   <= 1'b0;
         eng_data  <= '0;
         host_ack  <= 1'b0;
         host_data <= '0;
      end else begin
         eng_ack  <= eng_rd;
         host_ack <= host_srv;
         if (eng_rd) eng_data <= eng_fld;
         if (host_srv)
            host_data <= h_hi ? host_fld[FIELD_W-1 -: BYTE_W] : host_fld[BYTE_W-1:0];
         if (host_srv) begin
            pend_q <= 1'b0;
         end else if (host_rd && !pend_q) begin
            pend_q  <= 1'b1;
            pcode_q <= host_code;
            phi_q   <= host_hi;
         end
      end
   end

   assert_engine_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rd && host_rd && !pend_q) |=> (eng_ack && !host_ack && pend_q));

   assert_pending_served_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !eng_rd) |=> (host_ack && !pend_q));

   assert_unused_code_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rd && eng_code >= CODE_W'(NUM_FIELDS)) |=> (eng_data == '0));

   assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rd && empty) |=> (eng_data == '0));
endmodule

// File: rtl/sset_buf_ctrl.sv
module sset_buf_ctrl
   import sset_pkg::*;
#(
   parameter int FIELD_W = DEF_FIELD_W,
   parameter int DEPTH   = DEF_DEPTH,
   parameter int CODE_W  = DEF_CODE_W,
   localparam int BYTE_W = FIELD_W / 2,
   localparam int PTR_W  = $clog2(DEPTH),
   localparam int SET_W  = NUM_FIELDS * FIELD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [FIELD_W-1:0] in_i,
   input  logic [FIELD_W-1:0] in_q,
   input  logic [FIELD_W-1:0] in_mag,
   input  logic [FIELD_W-1:0] in_phase,
   input  logic [FIELD_W-1:0] in_freq,
   input  logic               in_freq_vld,
   input  logic               mode_snap,
   input  logic               snap_arm,
   input  logic               eng_rd,
   input  logic [CODE_W-1:0]  eng_code,
   output logic [FIELD_W-1:0] eng_data,
   output logic               eng_ack,
   input  logic               host_rd,
   input  logic [CODE_W-1:0]  host_code,
   input  logic               host_hi,
   output logic [BYTE_W-1:0]  host_data,
   output logic               host_ack,
   output logic               empty,
   output logic               full,
   output logic               snap_done
);
   if (FIELD_W < 2 || (FIELD_W % 2) != 0) begin : g_chk_fw
      $error("FIELD_W must be an even width of at least 2");
   end
   if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_chk_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if ((1 << CODE_W) < NUM_FIELDS) begin : g_chk_code
      $error("CODE_W too narrow for the field count");
   end

   logic             wr_en, pop;
   logic [PTR_W-1:0] wr_addr, rd_addr;
   logic [SET_W-1:0] head_set;

   sset_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
      .clk, .rst_n, .mode_snap, .snap_arm, .in_valid, .pop,
      .wr_en, .wr_addr, .rd_addr, .empty, .full, .snap_done
   );

   sset_store #(.FIELD_W(FIELD_W), .DEPTH(DEPTH)) store_i (
      .clk, .rst_n, .wr_en, .wr_addr, .in_i, .in_q, .in_mag, .in_phase,
      .in_freq, .in_freq_vld, .rd_addr, .head_set
   );

   sset_rd_arb #(.FIELD_W(FIELD_W), .CODE_W(CODE_W)) arb_i (
      .clk, .rst_n, .head_set, .empty, .eng_rd, .eng_code, .eng_data, .eng_ack,
      .host_rd, .host_code, .host_hi, .host_data, .host_ack, .pop
   );
endmodule

// File: tb/sset_buf_ctrl_tb_top.sv
module sset_buf_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 0, in_freq_vld = 0, mode_snap = 0, snap_arm = 0;
   logic [15:0] in_i = 0, in_q = 0, in_mag = 0, in_phase = 0, in_freq = 0;
   logic        eng_rd = 0, host_rd = 0, host_hi = 0;
   logic [2:0]  eng_code = 0, host_code = 0;
   logic [15:0] eng_data;
   logic [7:0]  host_data;
   logic        eng_ack, host_ack, empty, full, snap_done;

   int compared = 0;
   int mismatched = 0;

   always #5 clk = ~clk;

   sset_buf_ctrl dut_i (
      .clk, .rst_n, .in_valid, .in_i, .in_q, .in_mag, .in_phase, .in_freq,
      .in_freq_vld, .mode_snap, .snap_arm, .eng_rd, .eng_code, .eng_data,
      .eng_ack, .host_rd, .host_code, .host_hi, .host_data, .host_ack,
      .empty, .full, .snap_done
   );

   typedef struct packed {
      logic        host;
      logic [2:0]  code;
      logic        hi;
      logic [15:0] exp;
      logic [15:0] tag;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 3'd0, 1'b0, 16'hA000, "R3"},  // I of set 0
      '{1'b1, 3'd1, 1'b1, 16'h00A0, "R4"},  // upper byte of Q
      '{1'b1, 3'd1, 1'b0, 16'h0011, "R4"},  // lower byte of Q
      '{1'b0, 3'd6, 1'b0, 16'h0000, "R6"},  // unused code
      '{1'b0, 3'd2, 1'b0, 16'hA022, "R3"},  // magnitude
      '{1'b1, 3'd3, 1'b0, 16'h0033, "R4"},  // phase low byte
      '{1'b0, 3'd4, 1'b0, 16'hA044, "R5"},  // frequency, retires set 0
      '{1'b0, 3'd1, 1'b0, 16'hA111, "R5"},  // now set 1
      '{1'b1, 3'd4, 1'b0, 16'h0044, "R8"},  // held freq, retires set 1
      '{1'b1, 3'd0, 1'b0, 16'h0000, "R5"}   // empty read
   };

   function automatic logic [15:0] fval(input logic [15:0] base, input int s, input int f);
      return base + 16'(s * 256) + 16'(f * 17);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic write_set(input logic [15:0] base, input int s, input logic fv);
      @(negedge clk);
      in_valid = 1; in_freq_vld = fv;
      in_i = fval(base, s, 0); in_q = fval(base, s, 1); in_mag = fval(base, s, 2);
      in_phase = fval(base, s, 3); in_freq = fv ? fval(base, s, 4) : 16'hFFFF;
      @(negedge clk);
      in_valid = 0; in_freq_vld = 0;
   endtask

   task automatic do_read(input logic host, input logic [2:0] code, input logic hi,
                          output logic [15:0] d, output logic ack);
      @(negedge clk);
      if (host) begin host_rd = 1; host_code = code; host_hi = hi; end
      else begin eng_rd = 1; eng_code = code; end
      @(negedge clk);
      host_rd = 0; eng_rd = 0;
      ack = host ? host_ack : eng_ack;
      d   = host ? {8'h00, host_data} : eng_data;
   endtask

   initial begin
      #(200000 * 10);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic        a;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 empty", 32'(empty), 1);
      check("R1 full", 32'(full), 0);
      check("R1 snap_done", 32'(snap_done), 0);
      check("R1 acks", {30'd0, eng_ack, host_ack}, 0);
      rst_n = 1;

      // Vector table: two sets, the second without a frequency strobe
      write_set(16'hA000, 0, 1'b1);
      write_set(16'hA000, 1, 1'b0);
      check("R2 not empty", 32'(empty), 0);
      for (int v = 0; v < NV; v++) begin
         do_read(VECS[v].host, VECS[v].code, VECS[v].hi, d, a);
         check({string'(VECS[v].tag), " ack"}, 32'(a), 1);
         check({string'(VECS[v].tag), " data"}, 32'(d), 32'(VECS[v].exp));
      end
      check("R5 empty after retiring both", 32'(empty), 1);

      // R2 FIFO overflow: nine offered, eight kept
      for (int s = 0; s < 9; s++) begin
         write_set(16'hB000, s, 1'b1);
         if (s == 7) check("R2 full at eight", 32'(full), 1);
      end
      check("R2 full after drop", 32'(full), 1);
      do_read(1'b1, 3'd7, 1'b1, d, a);
      check("R6 host code 7", 32'(d), 0);
      check("R6 no retire", 32'(full), 1);
      for (int s = 0; s < 8; s++) begin
         do_read(1'b0, 3'd4, 1'b0, d, a);
         check("R2 order", 32'(d), 32'(fval(16'hB000, s, 4)));
      end
      check("R2 empty after eight", 32'(empty), 1);

      // R7 arbitration
      write_set(16'hC000, 5, 1'b1);
      @(negedge clk);
      eng_rd = 1; eng_code = 3'd0; host_rd = 1; host_code = 3'd1; host_hi = 1;
      @(negedge clk);
      eng_rd = 0; host_rd = 0;
      check("R7 engine ack", 32'(eng_ack), 1);
      check("R7 engine data", 32'(eng_data), 32'(fval(16'hC000, 5, 0)));
      check("R7 host waits", 32'(host_ack), 0);
      @(negedge clk);
      check("R7 host ack", 32'(host_ack), 1);
      check("R7 host data", 32'(host_data), 32'hC5);

      // R9 snapshot: arm wins over a same-cycle write
      @(negedge clk);
      mode_snap = 1; snap_arm = 1; in_valid = 1;
      @(negedge clk);
      snap_arm = 0; in_valid = 0;
      check("R9 arm empties", 32'(empty), 1);
      check("R9 done cleared", 32'(snap_done), 0);
      for (int s = 0; s < 10; s++) begin
         write_set(16'hD000, s, 1'b1);
         if (s == 6) check("R9 not done at seven", 32'(snap_done), 0);
      end
      check("R9 full", 32'(full), 1);
      check("R9 done", 32'(snap_done), 1);
      for (int s = 0; s < 8; s++) begin
         do_read(1'b0, 3'd4, 1'b0, d, a);
         check("R9 captured order", 32'(d), 32'(fval(16'hD000, s, 4)));
      end
      check("R9 empty after drain", 32'(empty), 1);
      check("R9 done held", 32'(snap_done), 1);
      write_set(16'hE000, 0, 1'b1);
      check("R10 write ignored", 32'(empty), 1);
      @(negedge clk); snap_arm = 1;
      @(negedge clk); snap_arm = 0;
      check("R9 rearm clears done", 32'(snap_done), 0);
      write_set(16'hE000, 1, 1'b1);
      check("R9 capture resumes", 32'(empty), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule